// File: doc/BRIEF.md
# Status Register Write Mask Unit

This unit keeps a 32-bit current status word and one saved status word. Each cycle it accepts at most one operation: a read of either word, or a masked write to either word. A write operand is either a full register value or an 8-bit constant rotated right by twice a 4-bit amount. Four field-select bits choose which bytes of the operand may land. Fixed masks then narrow the write to the condition flags, the execution-state bit and the privileged control bits (interrupt masks and mode). The control bits are locked while the current mode is user mode. The mode field is kept legal by forcing its top bit to one.

After every write to the current word the unit raises a one-cycle refill pulse, so that a fetch stage can reload its two prefetch slots. Reads return the whole packed word one cycle after the request.

Top module: `psr_write_unit`

## Requirements
- R1: Synchronous active-high reset sets the current word to 0x000000D3 (mode 0x13, both interrupt masks set) and the saved word to 0x00000000. It also clears refill, rd_valid and rd_data.
- R2: fld_sel[0] (instruction bit 16) enables byte 0 and fld_sel[3] (instruction bit 19) enables byte 3. fld_sel[1] and fld_sel[2] enable nothing. Bits 27:8 of the current word never change after reset.
- R3: With fld_sel[3] set, current-word bits 31:28 take the operand's bits in any mode. Bits 27:24 are not written.
- R4: With fld_sel[0] set, current-word bit 5 takes the operand's bit 5 in any mode, user mode included.
- R5: With fld_sel[0] set and the current mode (bits 4:0) not equal to 0x10, bits 7, 6 and 3:0 take the operand's bits and bit 4 is set to one.
- R6: With the current mode equal to 0x10 (user), bits 7, 6 and 3:0 of the current word keep their value on any write.
- R7: A saved-word write replaces the bits under (byte mask AND 0xF00000EF) with the operand and then ORs in 0x00000010, even when no field bit is set.
- R8: With op_imm=1 the operand is imm_field[7:0] rotated right by 2*imm_field[11:8]. With op_imm=0 it is reg_val.
- R9: op_kind 2'b00 reads the current word and 2'b01 reads the saved word. rd_valid is high, and rd_data holds the word as of the request cycle, in the cycle after the request. A read right after a write returns the written value.
- R10: refill is high for exactly the cycle after each current-word write (op_kind 2'b10). Saved-word writes (2'b11) and reads leave it low.
- R11: While op_valid is low, neither word changes, refill stays low and rd_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 00 read current, 01 read saved, 10 write current, 11 write saved |
| op_imm | input | 1 | Use rotated constant as operand |
| fld_sel | input | 4 | Field-select bits (instruction bits 19:16) |
| imm_field | input | 12 | Rotate amount [11:8] and constant [7:0] |
| reg_val | input | 32 | Register operand |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved status word |
| rd_data | output | 32 | Read result |
| rd_valid | output | 1 | rd_data valid |
| refill | output | 1 | One-cycle prefetch reload request |

## Verification
The refill pulse from a current-word write falls in the same cycle as a read issued right behind that write. That read must already return the new value. The bench provokes this with back-to-back write-then-read pairs and with chains of writes that keep refill high for several cycles. A behavioural model predicts refill, rd_valid and rd_data for every clock, and the bench compares them with the unit in each cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int PSR_W   = 32;
    localparam int MODE_W  = 5;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        OP_RD_CUR = 2'b00,
        OP_RD_SAV = 2'b01,
        OP_WR_CUR = 2'b10,
        OP_WR_SAV = 2'b11
    } psr_op_e;

    // Fixed write masks
    localparam logic [PSR_W-1:0] FLAG_BITS  = 32'hF000_0000;
    localparam logic [PSR_W-1:0] STATE_BITS = 32'h0000_0020;
    localparam logic [PSR_W-1:0] CTRL_BITS  = 32'h0000_00CF;
    localparam logic [PSR_W-1:0] MODE_TOP   = 32'h0000_0010;
    localparam logic [PSR_W-1:0] ANY_BITS   = FLAG_BITS | STATE_BITS | CTRL_BITS;

    localparam logic [MODE_W-1:0] USER_MODE = 5'h10;
    localparam logic [PSR_W-1:0]  CUR_RESET = 32'h0000_00D3;
    localparam logic [PSR_W-1:0]  SAV_RESET = 32'h0000_0000;

    typedef struct packed {
        logic            valid;
        psr_op_e         kind;
        logic [PSR_W-1:0] operand;
    } psr_req_t;

    typedef struct packed {
        logic [PSR_W-1:0] cur_en;
        logic [PSR_W-1:0] sav_en;
        logic             ctrl_hit;
    } psr_wmask_t;

    function automatic logic [PSR_W-1:0] rotr32(input logic [PSR_W-1:0] v,
                                                input logic [4:0] amt);
        logic [5:0] back;
        back = 6'd32 - {1'b0, amt};
        return (v >> amt) | (v << back);
    endfunction

    function automatic logic is_user(input logic [MODE_W-1:0] m);
        return m == USER_MODE;
    endfunction

endpackage

// File: rtl/psr_operand_gen.sv
module psr_operand_gen
    import psr_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic                     use_imm,
    input  logic [IMM_W+ROT_W-1:0]   imm_field,
    input  logic [PSR_W-1:0]         reg_val,
    output logic [PSR_W-1:0]         operand
);
    localparam int FIELD_W = IMM_W + ROT_W;
    localparam int AMT_W   = ROT_W + 1;

    logic [PSR_W-1:0] imm_ext;
    logic [AMT_W-1:0] rot_amt;
    logic [PSR_W-1:0] imm_rot;

    // Rotation is twice the encoded amount
    assign rot_amt = {imm_field[FIELD_W-1:IMM_W], 1'b0};
    assign imm_ext = {{(PSR_W-IMM_W){1'b0}}, imm_field[IMM_W-1:0]};

    generate
        if (AMT_W == 5) begin : g_rot32
            assign imm_rot = rotr32(imm_ext, rot_amt);
        end else begin : g_rot_generic
            always_comb begin
                imm_rot = imm_ext;
                for (int k = 0; k < (1 << AMT_W); k++) begin
                    if (k < int'(rot_amt))
                        imm_rot = {imm_rot[0], imm_rot[PSR_W-1:1]};
                end
            end
        end
    endgenerate

    assign operand = use_imm ? imm_rot : reg_val;

endmodule

// File: rtl/psr_mask_gen.sv
module psr_mask_gen
    import psr_pkg::*;
#(
    parameter int FLD_CNT = 4
) (
    input  logic [FLD_CNT-1:0] fld_sel,
    input  logic [MODE_W-1:0]  cur_mode,
    output psr_wmask_t         wmask
);
    logic [PSR_W-1:0] byte_en;
    logic [PSR_W-1:0] cur_allow;
    logic             privileged;

    // One field bit per byte lane
    generate
        for (genvar i = 0; i < FLD_CNT; i++) begin : g_lane
            assign byte_en[BYTE_W*i +: BYTE_W] = {BYTE_W{fld_sel[i]}};
        end
        if (FLD_CNT * BYTE_W < PSR_W) begin : g_pad
            assign byte_en[PSR_W-1:FLD_CNT*BYTE_W] = '0;
        end
    endgenerate

    assign privileged = !is_user(cur_mode);
    assign cur_allow  = FLAG_BITS | STATE_BITS | (privileged ? CTRL_BITS : '0);

    always_comb begin
        wmask.cur_en   = byte_en & cur_allow;
        wmask.sav_en   = byte_en & ANY_BITS;
        wmask.ctrl_hit = |(wmask.cur_en & CTRL_BITS);
    end

endmodule

// File: rtl/psr_regs.sv
module psr_regs
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  psr_req_t          req,
    input  psr_wmask_t        wmask,
    output logic [PSR_W-1:0]  cur_q,
    output logic [PSR_W-1:0]  sav_q,
    output logic [PSR_W-1:0]  rd_q,
    output logic              rd_valid_q,
    output logic              refill_q
);
    logic wr_cur, wr_sav, rd_any;
    logic [PSR_W-1:0] cur_d, sav_d, rd_sel;

    assign wr_cur = req.valid && (req.kind == OP_WR_CUR);
    assign wr_sav = req.valid && (req.kind == OP_WR_SAV);
    assign rd_any = req.valid && !req.kind[1];

    always_comb begin
        cur_d = (cur_q & ~wmask.cur_en) | (req.operand & wmask.cur_en);
        if (wmask.ctrl_hit)
            cur_d = cur_d | MODE_TOP;
        sav_d = (sav_q & ~wmask.sav_en) | (req.operand & wmask.sav_en) | MODE_TOP;
        rd_sel = (req.kind == OP_RD_SAV) ? sav_q : cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= CUR_RESET;
            sav_q      <= SAV_RESET;
            rd_q       <= '0;
            rd_valid_q <= 1'b0;
            refill_q   <= 1'b0;
        end else begin
            if (wr_cur) cur_q <= cur_d;
            if (wr_sav) sav_q <= sav_d;
            if (rd_any) rd_q  <= rd_sel;
            rd_valid_q <= rd_any;
            refill_q   <= wr_cur;
        end
    end

    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cur_q[27:8]));                                  // R2
    AST_MODE_TOP_SET: assert property (@(posedge clk) disable iff (rst)
        cur_q[4]);                                                       // R5
    AST_USER_CTRL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (wr_cur && is_user(cur_q[4:0])) |=>
        (cur_q[7:6] == $past(cur_q[7:6]) && cur_q[3:0] == $past(cur_q[3:0]))); // R6
    AST_SAV_MODE_TOP: assert property (@(posedge clk) disable iff (rst)
        wr_sav |=> sav_q[4]);                                            // R7
    AST_SAV_NO_REFILL: assert property (@(posedge clk) disable iff (rst)
        wr_sav |=> !refill_q);                                           // R10
    AST_CUR_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_cur |=> $stable(cur_q));                                     // R11
    AST_SAV_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_sav |=> $stable(sav_q));                                     // R11

endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
    import psr_pkg::*;
#(
    parameter int IMM_W   = 8,
    parameter int ROT_W   = 4,
    parameter int FLD_CNT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic [1:0]               op_kind,
    input  logic                     op_imm,
    input  logic [FLD_CNT-1:0]       fld_sel,
    input  logic [IMM_W+ROT_W-1:0]   imm_field,
    input  logic [31:0]              reg_val,
    output logic [31:0]              cur_psr,
    output logic [31:0]              saved_psr,
    output logic [31:0]              rd_data,
    output logic                     rd_valid,
    output logic                     refill
);
    logic [PSR_W-1:0] operand;
    psr_req_t         req;
    psr_wmask_t       wmask;
    logic [PSR_W-1:0] cur_q;

    psr_operand_gen #(.IMM_W(IMM_W), .ROT_W(ROT_W)) u_opnd (
        .use_imm   (op_imm),
        .imm_field (imm_field),
        .reg_val   (reg_val),
        .operand   (operand)
    );

    psr_mask_gen #(.FLD_CNT(FLD_CNT)) u_mask (
        .fld_sel  (fld_sel),
        .cur_mode (cur_q[MODE_W-1:0]),
        .wmask    (wmask)
    );

    always_comb begin
        req.valid   = op_valid;
        req.kind    = psr_op_e'(op_kind);
        req.operand = operand;
    end

    psr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .wmask      (wmask),
        .cur_q      (cur_q),
        .sav_q      (saved_psr),
        .rd_q       (rd_data),
        .rd_valid_q (rd_valid),
        .refill_q   (refill)
    );

    assign cur_psr = cur_q;

    AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b00) |=> (rd_valid && rd_data == $past(cur_q))); // R9

endmodule

// File: tb/sim_psr_write_unit.sv
module sim_psr_write_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic        op_imm;
    logic [3:0]  fld_sel;
    logic [11:0] imm_field;
    logic [31:0] reg_val;
    logic [31:0] cur_psr, saved_psr, rd_data;
    logic        rd_valid, refill;

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [31:0] m_cur, m_sav, m_rd;
    logic        m_rdv, m_ref;

    always #10 clk = ~clk;

    psr_write_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_imm(op_imm), .fld_sel(fld_sel), .imm_field(imm_field),
        .reg_val(reg_val), .cur_psr(cur_psr), .saved_psr(saved_psr),
        .rd_data(rd_data), .rd_valid(rd_valid), .refill(refill)
    );

    function automatic logic [31:0] m_operand(input logic im, input logic [11:0] f,
                                              input logic [31:0] rv);
        logic [31:0] x;
        if (!im) return rv;
        x = {24'h0, f[7:0]};
        for (int k = 0; k < 2 * int'(f[11:8]); k++) x = {x[0], x[31:1]};
        return x;
    endfunction

    task automatic model_clock(input logic v, input logic [1:0] k, input logic [31:0] op,
                               input logic [3:0] fs);
        logic [31:0] fm, n;
        fm = 32'h0;
        if (fs[0]) fm = fm | 32'h0000_00FF;
        if (fs[3]) fm = fm | 32'hFF00_0000;
        m_ref = v && (k == 2'b10);
        m_rdv = v && (k[1] == 1'b0);
        if (m_rdv) m_rd = k[0] ? m_sav : m_cur;
        if (v && k == 2'b10) begin
            n = m_cur;
            if ((fm & 32'hF000_0000) != 0) n = (n & ~32'hF000_0000) | (op & 32'hF000_0000);
            if ((fm & 32'h20) != 0) n[5] = op[5];
            if (m_cur[4:0] != 5'h10 && (fm & 32'hCF) != 0) begin
                n = (n & ~32'hCF) | (op & 32'hCF);
                n[4] = 1'b1;
            end
            m_cur = n;
        end
        if (v && k == 2'b11) begin
            fm = fm & 32'hF000_00EF;
            m_sav = (m_sav & ~fm) | (op & fm) | 32'h10;
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "cur_psr", cur_psr, m_cur);
        chk(tag, "saved_psr", saved_psr, m_sav);
        chk("R10", "refill", {31'h0, refill}, {31'h0, m_ref});
        chk("R9", "rd_valid", {31'h0, rd_valid}, {31'h0, m_rdv});
        if (m_rdv) chk("R9", "rd_data", rd_data, m_rd);
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic im,
                        input logic [3:0] fs, input logic [11:0] f,
                        input logic [31:0] rv, input string tag);
        op_valid = v; op_kind = k; op_imm = im; fld_sel = fs;
        imm_field = f; reg_val = rv;
        @(posedge clk);
        model_clock(v, k, m_operand(im, f, rv), fs);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; op_valid = 1'b0; op_kind = 2'b00; op_imm = 1'b0;
        fld_sel = 4'h0; imm_field = 12'h0; reg_val = 32'h0;
        repeat (2) @(posedge clk);
        m_cur = 32'h0000_00D3; m_sav = 32'h0; m_rd = 32'h0; m_rdv = 1'b0; m_ref = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");
        chk("R1", "rd_data", rd_data, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "cur reset value", cur_psr, 32'h0000_00D3);
        // R5: privileged write of flags and control from a register
        step(1, 2'b10, 0, 4'b1001, 12'h0, 32'hA5FF_FF3F, "R5");
        chk("R5", "cur after privileged write", cur_psr, 32'hA000_003F);
        // R9: read immediately behind the write, refill in same cycle
        step(1, 2'b00, 0, 4'h0, 12'h0, 32'h0, "R9");
        chk("R9", "read after write", rd_data, 32'hA000_003F);
        // R8: immediate forms
        step(1, 2'b10, 1, 4'b1000, 12'h20F, 32'hDEAD_BEEF, "R8");
        chk("R8", "rotated flags", cur_psr, 32'hF000_003F);
        step(1, 2'b10, 1, 4'b0001, 12'h0D3, 32'h0, "R8");
        step(1, 2'b10, 1, 4'b0001, 12'hF81, 32'h0, "R8");
        // R2: middle field bits do nothing
        step(1, 2'b10, 0, 4'b0110, 12'h0, 32'hFFFF_FFFF, "R2");
        step(1, 2'b10, 0, 4'b1111, 12'h0, 32'h0FFF_FF00, "R2");
        // R3: flag byte only, lower nibble of it never lands
        step(1, 2'b10, 0, 4'b1000, 12'h0, 32'h5F00_0000, "R3");
        // R7: saved word
        step(1, 2'b11, 0, 4'b0000, 12'h0, 32'hFFFF_FFFF, "R7");
        chk("R7", "saved empty write", saved_psr, 32'h0000_0010);
        step(1, 2'b11, 0, 4'b1001, 12'h0, 32'hFFFF_FFFF, "R7");
        chk("R7", "saved full write", saved_psr, 32'hF000_00FF);
        step(1, 2'b11, 0, 4'b0001, 12'h0, 32'h0, "R7");
        step(1, 2'b01, 0, 4'h0, 12'h0, 32'h0, "R9");
        // R6/R4: enter user mode, then try control writes
        step(1, 2'b10, 0, 4'b0001, 12'h0, 32'h0000_0010, "R6");
        step(1, 2'b10, 0, 4'b0001, 12'h0, 32'h0000_00FF, "R6");
        chk("R4", "state bit in user mode", {31'h0, cur_psr[5]}, 32'h1);
        chk("R6", "mode locked", {27'h0, cur_psr[4:0]}, 32'h10);
        step(1, 2'b10, 1, 4'b1001, 12'h4F5, 32'h0, "R3");
        step(1, 2'b10, 0, 4'b0001, 12'h0, 32'h0, "R4");
        // R11: idle with junk
        step(0, 2'b10, 0, 4'b1111, 12'hFFF, 32'hFFFF_FFFF, "R11");
        step(0, 2'b11, 0, 4'b1111, 12'hFFF, 32'hFFFF_FFFF, "R11");
        step(0, 2'b00, 0, 4'b1111, 12'hFFF, 32'hFFFF_FFFF, "R11");
        // R10: back-to-back current writes, then saved write
        do_reset();
        step(1, 2'b10, 0, 4'b1001, 12'h0, 32'h8000_0011, "R10");
        step(1, 2'b10, 0, 4'b1001, 12'h0, 32'h4000_001F, "R10");
        step(1, 2'b11, 0, 4'b1001, 12'h0, 32'h1234_5678, "R10");
        step(1, 2'b00, 0, 4'h0, 12'h0, 32'h0, "R9");
        // Mixed traffic
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] s = $urandom;
            if (i == 200) do_reset();
            step(r[0] | r[1], r[3:2], r[4], r[8:5], r[20:9], s, "R2");
        end
        step(0, 2'b00, 0, 4'h0, 12'h0, 32'h0, "R11");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule